// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is the execute core of a simple processor. Seven general-purpose registers, together with an external data input, feed two operand buses. An ALU combines the two operands, and the result is written back into one chosen register. Each clock cycle is steered by a single 14-bit control word. In one cycle the word names the two sources, the destination and the operation, so operand read, ALU evaluation and write-back all complete in that cycle.

A status register keeps the carry, sign, zero and overflow conditions from the most recent operation that updates flags. The contents of every register and the status bits are visible on read-back outputs. A sequencer outside the block supplies one control word per cycle and uses those outputs.

Top module: `regdp_top`

## Requirements
- R1: While `rst_n` is low, all seven registers read back as zero and `flags` is 0000.
- R2: The control word bits are laid out as [13:11] A-source select, [10:8] B-source select, [7:5] destination select and [4:0] operation. A source select of 1..7 puts register 1..7 on that bus, and a source select of 0 puts `ext_data` on it. Register k appears on `regs_flat[(k-1)*W +: W]`.
- R3: A destination select of 1..7 writes the ALU result into that register on the rising edge. All other registers stay unchanged. A destination select of 0 writes no register.
- R4: Operation 00001 writes A+B modulo 2^W and sets carry (`flags[3]`) to the carry out of the top bit.
- R5: Operation 00010 writes A-B modulo 2^W and sets carry to 1 exactly when A < B as unsigned numbers, which is a borrow.
- R6: For add and subtract, overflow (`flags[0]`) is 1 exactly when the signed two's-complement result is outside the range of W bits. This is the same as the XOR of the carry into and the carry out of the top bit.
- R7: Operation 00100 writes A AND B, 00011 writes A OR B, 00101 writes A XOR B, and 00000 writes A. All four clear carry and overflow.
- R8: For every defined operation, sign (`flags[2]`) equals the top bit of the result, and zero (`flags[1]`) is 1 exactly when the result is all zeros.
- R9: Any other operation code writes A to the destination and leaves all four flags unchanged.
- R10: Source reads are combinational from the register state before the edge. A register used as both source and destination supplies its old value, and the new value shows from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 14 | Source, destination and operation fields |
| ext_data | input | W | Operand routed onto a bus by select code 0 |
| regs_flat | output | 7*W | Contents of registers 1..7, register 1 in the low bits |
| flags | output | 4 | {carry, sign, zero, overflow} |

## Verification
The hardest conditions to reach are the signed-overflow cases of subtraction and the rule that undefined codes keep the flags. The overflow cases need operands placed exactly at the signed range limits, such as 0x80 minus 1 and 0x7F plus 1. The flag-keeping rule can only be seen when the flags already hold non-zero values. Directed sequences first load the boundary operands through the external input and then drive the flags to known set states before issuing undefined codes. Random control words follow, and they mix defined codes with arbitrary five-bit codes.

// File: rtl/regdp_pkg.sv
package regdp_pkg;
    localparam int SEL_W = 3;
    localparam int OP_W  = 5;
    localparam int NREG  = (1 << SEL_W) - 1;
    localparam int CW_W  = 3 * SEL_W + OP_W;

    localparam logic [OP_W-1:0] OP_PASS = 5'b00000;
    localparam logic [OP_W-1:0] OP_ADD  = 5'b00001;
    localparam logic [OP_W-1:0] OP_SUB  = 5'b00010;
    localparam logic [OP_W-1:0] OP_OR   = 5'b00011;
    localparam logic [OP_W-1:0] OP_AND  = 5'b00100;
    localparam logic [OP_W-1:0] OP_XOR  = 5'b00101;

    typedef struct packed {
        logic c;
        logic s;
        logic z;
        logic v;
    } flags_t;
endpackage

// File: rtl/regdp_srcmux.sv
module regdp_srcmux
    import regdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NREG*W-1:0] regs_flat,
    input  logic [W-1:0]      ext_data,
    input  logic [SEL_W-1:0]  sel,
    output logic [W-1:0]      opnd
);
    always_comb begin
        opnd = ext_data;
        for (int i = 1; i <= NREG; i++) begin
            if (sel == SEL_W'(i)) begin
                opnd = regs_flat[(i-1)*W +: W];
            end
        end
    end
endmodule

// File: rtl/regdp_regfile.sv
module regdp_regfile
    import regdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  waddr,
    input  logic [W-1:0]      wdata,
    output logic [NREG*W-1:0] regs_flat
);
    logic [W-1:0] regs_d [1:NREG];
    logic [W-1:0] regs_q [1:NREG];

    always_comb begin
        for (int i = 1; i <= NREG; i++) begin
            regs_d[i] = regs_q[i];
            if (waddr == SEL_W'(i)) begin
                regs_d[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 1; i <= NREG; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 1; i <= NREG; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    for (genvar g = 1; g <= NREG; g++) begin : g_flat
        assign regs_flat[(g-1)*W +: W] = regs_q[g];
    end
endmodule

// File: rtl/regdp_alu.sv
module regdp_alu
    import regdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OP_W-1:0] op,
    output logic [W-1:0]    res,
    output flags_t          fl,
    output logic            upd
);
    logic            is_sub;
    logic [W-1:0]    b_eff;
    logic [W-1:0]    low_sum;
    logic [W:0]      full_sum;
    logic            c_into_msb;
    logic            c_out_msb;

    always_comb begin
        is_sub     = (op == OP_SUB);
        b_eff      = is_sub ? ~b : b;
        low_sum    = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, is_sub};
        full_sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, is_sub};
        c_into_msb = low_sum[W-1];
        c_out_msb  = full_sum[W];

        res  = a;
        fl   = '0;
        upd  = 1'b1;
        case (op)
            OP_ADD: begin
                res  = full_sum[W-1:0];
                fl.c = c_out_msb;
                fl.v = c_into_msb ^ c_out_msb;
            end
            OP_SUB: begin
                res  = full_sum[W-1:0];
                fl.c = ~c_out_msb;
                fl.v = c_into_msb ^ c_out_msb;
            end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_PASS: res = a;
            default: begin
                res = a;
                upd = 1'b0;
            end
        endcase
        fl.s = res[W-1];
        fl.z = (res == '0);
    end
endmodule

// File: rtl/regdp_top.sv
module regdp_top
    import regdp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW_W-1:0]   ctrl_word,
    input  logic [W-1:0]      ext_data,
    output logic [NREG*W-1:0] regs_flat,
    output logic [3:0]        flags
);
    localparam int SA_LSB = 2 * SEL_W + OP_W;
    localparam int SB_LSB = SEL_W + OP_W;
    localparam int SD_LSB = OP_W;

    logic [SEL_W-1:0] sel_a;
    logic [SEL_W-1:0] sel_b;
    logic [SEL_W-1:0] sel_d;
    logic [OP_W-1:0]  opcode;
    logic [W-1:0]     bus_a;
    logic [W-1:0]     bus_b;
    logic [W-1:0]     alu_res;
    flags_t           alu_fl;
    logic             alu_upd;
    flags_t           flags_d;
    flags_t           flags_q;

    always_comb begin
        sel_a  = ctrl_word[SA_LSB +: SEL_W];
        sel_b  = ctrl_word[SB_LSB +: SEL_W];
        sel_d  = ctrl_word[SD_LSB +: SEL_W];
        opcode = ctrl_word[0 +: OP_W];
    end

    regdp_srcmux #(.W(W)) u_mux_a (
        .regs_flat (regs_flat),
        .ext_data  (ext_data),
        .sel       (sel_a),
        .opnd      (bus_a)
    );

    regdp_srcmux #(.W(W)) u_mux_b (
        .regs_flat (regs_flat),
        .ext_data  (ext_data),
        .sel       (sel_b),
        .opnd      (bus_b)
    );

    regdp_alu #(.W(W)) u_alu (
        .a   (bus_a),
        .b   (bus_b),
        .op  (opcode),
        .res (alu_res),
        .fl  (alu_fl),
        .upd (alu_upd)
    );

    regdp_regfile #(.W(W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .waddr     (sel_d),
        .wdata     (alu_res),
        .regs_flat (regs_flat)
    );

    always_comb begin
        flags_d = flags_q;
        if (alu_upd) begin
            flags_d = alu_fl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/regdp_chk.sv
module regdp_chk
    import regdp_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CW_W-1:0]   ctrl_word,
    input logic [W-1:0]      ext_data,
    input logic [NREG*W-1:0] regs_flat,
    input logic [3:0]        flags
);
    function automatic logic [W-1:0] pick(input logic [NREG*W-1:0] f, input logic [SEL_W-1:0] k);
        logic [W-1:0] r;
        r = '0;
        for (int i = 1; i <= NREG; i++) begin
            if (k == SEL_W'(i)) r = f[(i-1)*W +: W];
        end
        return r;
    endfunction

    function automatic logic msb_of(input logic [W-1:0] x);
        return x[W-1];
    endfunction

    logic [SEL_W-1:0] c_sa;
    logic [SEL_W-1:0] c_sd;
    logic [OP_W-1:0]  c_op;
    logic             c_known;
    logic             c_logic;

    assign c_sa    = ctrl_word[2*SEL_W+OP_W +: SEL_W];
    assign c_sd    = ctrl_word[OP_W +: SEL_W];
    assign c_op    = ctrl_word[OP_W-1:0];
    assign c_known = (c_op inside {OP_PASS, OP_ADD, OP_SUB, OP_OR, OP_AND, OP_XOR});
    assign c_logic = (c_op inside {OP_PASS, OP_OR, OP_AND, OP_XOR});

    AST_NO_DEST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (c_sd == '0) |=> $stable(regs_flat)); // R3

    AST_UNUSED_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !c_known |=> $stable(flags)); // R9

    AST_LOGIC_CLEARS_CV: assert property (@(posedge clk) disable iff (!rst_n)
        c_logic |=> (flags[3] == 1'b0 && flags[0] == 1'b0)); // R7

    AST_EXT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (c_op == OP_PASS && c_sa == '0 && c_sd != '0) |=>
        (pick(regs_flat, $past(c_sd)) == $past(ext_data))); // R2

    AST_ZERO_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (c_known && c_sd != '0) |=>
        (flags[1] == (pick(regs_flat, $past(c_sd)) == '0) &&
         flags[2] == msb_of(pick(regs_flat, $past(c_sd))))); // R8
endmodule

bind regdp_top regdp_chk #(.W(W)) u_chk (.*);

// File: tb/tb_regdp_top.sv
module tb_regdp_top;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 7;

    logic            clk;
    logic            rst_n;
    logic [13:0]     ctrl_word;
    logic [W-1:0]    ext_data;
    logic [NR*W-1:0] regs_flat;
    logic [3:0]      flags;

    int checks;
    int failures;
    bit done;

    logic [W-1:0] m [1:NR];
    logic [3:0]   mf;

    regdp_top #(.W(W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_word (ctrl_word),
        .ext_data  (ext_data),
        .regs_flat (regs_flat),
        .flags     (flags)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [13:0] mk(input int sa, input int sb, input int sd, input int op);
        return {3'(sa), 3'(sb), 3'(sd), 5'(op)};
    endfunction

    function automatic logic [NR*W-1:0] model_flat();
        logic [NR*W-1:0] f;
        for (int i = 1; i <= NR; i++) f[(i-1)*W +: W] = m[i];
        return f;
    endfunction

    function automatic logic [W-1:0] rd(input logic [2:0] s, input logic [W-1:0] ext);
        return (s == 3'd0) ? ext : m[s];
    endfunction

    task automatic check(input string tag);
        checks++;
        if (regs_flat !== model_flat() || flags !== mf) begin
            failures++;
            $display("FAIL %s regs=%h flags=%b expected regs=%h flags=%b",
                     tag, regs_flat, flags, model_flat(), mf);
        end
    endtask

    // Model one edge of the datapath from the requirements, using pre-edge state (R10).
    task automatic model_edge(input logic [13:0] cw, input logic [W-1:0] ext);
        logic [W-1:0] a, b, r;
        int sa, sb, sum, sdiff;
        logic c, v, known;
        a = rd(cw[13:11], ext);
        b = rd(cw[10:8], ext);
        c = 1'b0; v = 1'b0; known = 1'b1;
        case (cw[4:0])
            5'd1: begin
                r = a + b;
                c = (int'(a) + int'(b)) > 255;
                sa = int'($signed(a)); sb = int'($signed(b)); sum = sa + sb;
                v = (sum > 127) || (sum < -128);
            end
            5'd2: begin
                r = a - b;
                c = a < b;
                sa = int'($signed(a)); sb = int'($signed(b)); sdiff = sa - sb;
                v = (sdiff > 127) || (sdiff < -128);
            end
            5'd4: r = a & b;
            5'd3: r = a | b;
            5'd5: r = a ^ b;
            5'd0: r = a;
            default: begin r = a; known = 1'b0; end
        endcase
        if (known) mf = {c, r[W-1], (r == 0), v};
        if (cw[7:5] != 3'd0) m[cw[7:5]] = r;
    endtask

    task automatic step(input logic [13:0] cw, input logic [W-1:0] ext, input string tag);
        ctrl_word = cw;
        ext_data  = ext;
        model_edge(cw, ext);
        @(posedge clk);
        @(negedge clk);
        check(tag);
    endtask

    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'd1:    return "R4";
            5'd2:    return "R5";
            5'd0, 5'd3, 5'd4, 5'd5: return "R7";
            default: return "R9";
        endcase
    endfunction

    initial begin
        checks = 0; failures = 0; done = 1'b0;
        rst_n = 1'b0; ctrl_word = '0; ext_data = '0;
        for (int i = 1; i <= NR; i++) m[i] = '0;
        mf = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1");
        ctrl_word = mk(0, 0, 1, 0); ext_data = 8'hAA;
        @(posedge clk);
        @(negedge clk);
        check("R1");
        rst_n = 1'b1;

        // R2 loads through the external input
        step(mk(0, 0, 1, 0), 8'h7F, "R2");
        step(mk(0, 0, 2, 0), 8'h01, "R2");
        step(mk(0, 0, 3, 0), 8'hFF, "R2");
        step(mk(0, 0, 4, 0), 8'h80, "R2");
        // R6 signed overflow on add and subtract
        step(mk(1, 2, 5, 1), 8'h00, "R6");
        step(mk(4, 2, 7, 2), 8'h00, "R6");
        // R4 carry and wrap to zero
        step(mk(3, 2, 6, 1), 8'h00, "R4");
        // R5 borrow, with R3 destination 0 writing nothing
        step(mk(0, 2, 0, 2), 8'h00, "R3");
        step(mk(2, 3, 5, 2), 8'h00, "R5");
        // R8 zero result
        step(mk(1, 1, 5, 2), 8'h00, "R8");
        // R9 undefined codes keep set flags
        step(mk(3, 3, 6, 1), 8'h00, "R4");
        step(mk(3, 2, 1, 5'b11111), 8'h00, "R9");
        step(mk(4, 2, 7, 2), 8'h00, "R6");
        step(mk(2, 1, 5, 5'b10110), 8'h3C, "R9");
        // R7 logic operations
        step(mk(3, 0, 2, 4), 8'h0F, "R7");
        step(mk(2, 0, 3, 3), 8'hF0, "R7");
        step(mk(3, 3, 4, 5), 8'h00, "R7");
        // R10 same register as source and destination
        step(mk(0, 0, 2, 0), 8'h21, "R2");
        step(mk(2, 2, 2, 1), 8'h00, "R10");
        step(mk(2, 0, 2, 2), 8'h02, "R10");

        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic [13:0] cw;
            int pick;
            cw = 14'($urandom);
            pick = int'($urandom % 10);
            if (pick < 6) cw[4:0] = 5'(pick);
            step(cw, 8'($urandom), tag_of(cw[4:0]));
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule